// File: doc/BRIEF.md
# Clock stall detector

This block watches a system clock from a separate, free-running reference clock and raises a reset request when the watched clock stops toggling. The watched clock is handled as a plain data signal. Its level is synchronised into the reference domain and compared with the previous sample, so a rising or a falling transition both count as activity. A counter measures the reference cycles since the last transition. When the watched clock keeps one level, high or low, for more than `TIMEOUT_CYC` reference cycles, the block raises a request. `TIMEOUT_CYC` is set to the number of reference cycles in 100 µs.

The detector runs only while its enable input is high. That input comes from a reset-flag register bit that software sets to 1 to turn the detector on and clears to 0 to turn it off. A detected stall also sets a cause flag, so that after the resulting reset software can see that this detector was the source. A reset from any other source clears the flag. The request stays high until the reset controller acknowledges it. The block drives no external reset pin.

Top module: `clk_stall_detector`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it, `stall_req` and `stall_flag` are 0 and the stall counter is clear.
- R2: With `det_enable` high, if `mon_clk` keeps one level (high or low) for more than `TIMEOUT_CYC` reference cycles, `stall_req` rises on reference edge number `TIMEOUT_CYC + SYNC_STAGES + 2` after the level change. The first reference edge after the change counts as edge 1.
- R3: A level held for `TIMEOUT_CYC` reference cycles or fewer produces no request. Every transition of `mon_clk` restarts the timing from zero.
- R4: A `mon_clk` that keeps toggling with a half period well below `TIMEOUT_CYC` never produces a request.
- R5: While `det_enable` is low, the counter is held clear and no request is made, however long `mon_clk` stalls. If `det_enable` rises while `mon_clk` is stuck, `stall_req` rises on the `TIMEOUT_CYC + 1`-th reference edge after the rise.
- R6: `stall_req` stays high until `req_ack` is sampled high, and falls on that edge. `req_ack` does not change `stall_flag`.
- R7: Each stall produces one request only. After an acknowledge, a level that stays stuck raises no new request until a transition occurs and a new full stall follows.
- R8: `stall_flag` is set on the same edge as `stall_req`. It is cleared by `other_rst`, which reports a reset from another source.
- R9: When a new trip and `req_ack` fall in the same cycle, the trip wins and `stall_req` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock; all state is in this domain |
| rst | input | 1 | Synchronous active-high reset |
| mon_clk | input | 1 | Watched system clock, sampled as data |
| det_enable | input | 1 | Detector enable, from the reset-flag register bit |
| req_ack | input | 1 | Acknowledge from the reset controller; clears the request |
| other_rst | input | 1 | One-cycle pulse when a reset from another source occurs |
| stall_req | output | 1 | Registered reset request from a detected stall |
| stall_flag | output | 1 | Registered cause flag: last reset came from this detector |

## Verification
The request latch can see a new trip and an acknowledge in the same cycle. The bench leaves a first request unacknowledged and lets the watched clock stall again. It then drives `req_ack` high for exactly the cycle in which the stall pulse is registered, and expects `stall_req` to stay high. A lone acknowledge on the next cycle must then clear it. The trip boundary is approached from both sides: a level held for exactly the timeout must pass quietly, and one cycle longer must trip on the predicted edge. This is done with the clock stuck high and again with it stuck low.

// File: rtl/csd_pkg.sv
`timescale 1ns/1ps
package csd_pkg;
  // Bits needed to hold counts 0 .. limit
  function automatic int unsigned cnt_bits(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/csd_level_sync.sv
`timescale 1ns/1ps
module csd_level_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/csd_edge_detect.sv
`timescale 1ns/1ps
module csd_edge_detect (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic edge_seen
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  // Either direction of change counts as activity
  assign edge_seen = lvl ^ prev_q;
endmodule

// File: rtl/csd_stall_timer.sv
`timescale 1ns/1ps
module csd_stall_timer #(
  parameter int TIMEOUT_CYC = 2000,
  parameter int CNT_W       = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             edge_seen,
  output logic [CNT_W-1:0] cnt,
  output logic             stall_pulse
);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(TIMEOUT_CYC);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic hit_next;
  assign hit_next = enable && !edge_seen && (cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst || !enable || edge_seen) begin
      cnt <= '0;
    end else if (cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  // One pulse per stall: fires only on the step into saturation
  always_ff @(posedge clk) begin
    if (rst) stall_pulse <= 1'b0;
    else     stall_pulse <= hit_next;
  end
endmodule

// File: rtl/csd_req_latch.sv
`timescale 1ns/1ps
module csd_req_latch (
  input  logic clk,
  input  logic rst,
  input  logic stall_pulse,
  input  logic req_ack,
  input  logic other_rst,
  output logic req_q,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (stall_pulse)  req_q <= 1'b1;
      else if (req_ack) req_q <= 1'b0;
      if (stall_pulse)    flag_q <= 1'b1;
      else if (other_rst) flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/clk_stall_detector.sv
`timescale 1ns/1ps
module clk_stall_detector
  import csd_pkg::*;
#(
  parameter int TIMEOUT_CYC = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic ref_clk,
  input  logic rst,
  input  logic mon_clk,
  input  logic det_enable,
  input  logic req_ack,
  input  logic other_rst,
  output logic stall_req,
  output logic stall_flag
);
  localparam int CNT_W = cnt_bits(TIMEOUT_CYC);

  logic             mon_lvl;
  logic             edge_seen;
  logic [CNT_W-1:0] cnt;
  logic             stall_pulse;

  csd_level_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (ref_clk),
    .rst (rst),
    .d   (mon_clk),
    .q   (mon_lvl)
  );

  csd_edge_detect u_edge (
    .clk       (ref_clk),
    .rst       (rst),
    .lvl       (mon_lvl),
    .edge_seen (edge_seen)
  );

  csd_stall_timer #(.TIMEOUT_CYC(TIMEOUT_CYC), .CNT_W(CNT_W)) u_timer (
    .clk         (ref_clk),
    .rst         (rst),
    .enable      (det_enable),
    .edge_seen   (edge_seen),
    .cnt         (cnt),
    .stall_pulse (stall_pulse)
  );

  csd_req_latch u_latch (
    .clk         (ref_clk),
    .rst         (rst),
    .stall_pulse (stall_pulse),
    .req_ack     (req_ack),
    .other_rst   (other_rst),
    .req_q       (stall_req),
    .flag_q      (stall_flag)
  );
endmodule

// File: rtl/csd_checker.sv
`timescale 1ns/1ps
module csd_checker #(
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             ack,
  input logic             other,
  input logic             edge_seen,
  input logic [CNT_W-1:0] cnt,
  input logic             stall_pulse,
  input logic             req,
  input logic             flag
);
  logic past_rst = 1'b0;

  always_ff @(posedge clk) begin
    past_rst <= rst;
    if (past_rst) begin
      assert_reset_clear_R1: assert (!req && !flag && cnt == '0)
        else $error("reset state wrong");
    end
  end

  assert_edge_restarts_R3: assert property (@(posedge clk) disable iff (rst)
    edge_seen |=> cnt == '0);

  assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!stall_pulse && cnt == '0));

  assert_hold_until_ack_R6: assert property (@(posedge clk) disable iff (rst)
    (req && !ack) |=> req);

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (ack && !stall_pulse) |=> !req);

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    stall_pulse |=> !stall_pulse);

  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (other && !stall_pulse) |=> !flag);

  assert_trip_wins_R9: assert property (@(posedge clk) disable iff (rst)
    stall_pulse |=> (req && flag));
endmodule

bind clk_stall_detector csd_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (ref_clk),
  .rst         (rst),
  .enable      (det_enable),
  .ack         (req_ack),
  .other       (other_rst),
  .edge_seen   (edge_seen),
  .cnt         (cnt),
  .stall_pulse (stall_pulse),
  .req         (stall_req),
  .flag        (stall_flag)
);

// File: tb/tb_clk_stall_detector.sv
`timescale 1ns/1ps
module tb_clk_stall_detector;
  localparam int T    = 32;
  localparam int SYNC = 2;
  localparam int LAT  = SYNC + 2;

  logic ref_clk = 1'b0, rst = 1'b1, mon_clk = 1'b0;
  logic det_enable = 1'b0, req_ack = 1'b0, other_rst = 1'b0;
  logic stall_req, stall_flag;

  clk_stall_detector #(.TIMEOUT_CYC(T), .SYNC_STAGES(SYNC)) dut (
    .ref_clk(ref_clk), .rst(rst), .mon_clk(mon_clk), .det_enable(det_enable),
    .req_ack(req_ack), .other_rst(other_rst),
    .stall_req(stall_req), .stall_flag(stall_flag)
  );

  always #2.5 ref_clk = ~ref_clk;

  int cyc = 0;
  always @(posedge ref_clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    logic  req;
    logic  flag;
    string tag;
  } exp_t;

  exp_t sb[$];
  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  // Driver side: expected outputs at the negedge k reference edges from now
  task automatic expect_out(input int k, input logic r, input logic f, input string tag);
    exp_t e;
    e.at = cyc + k; e.req = r; e.flag = f; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: compares due items away from the active edge
  always @(negedge ref_clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at == cyc) begin
        n_checks++;
        if (stall_req !== sb[i].req || stall_flag !== sb[i].flag) begin
          n_fail++;
          $display("FAIL %s: req=%b flag=%b expected req=%b flag=%b",
                   sb[i].tag, stall_req, stall_flag, sb[i].req, sb[i].flag);
        end
        sb.delete(i);
      end
    end
  end

  task automatic step();
    @(posedge ref_clk);
    @(negedge ref_clk);
  endtask

  task automatic wait_edges(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // Keep the current level for m reference edges, then toggle
  task automatic hold(input int m);
    wait_edges(m);
    mon_clk = ~mon_clk;
  endtask

  task automatic stall_round(input logic pol);
    // Clear the old request and flag together (R6, R8)
    req_ack = 1'b1; other_rst = 1'b1;
    expect_out(1, 1'b0, 1'b0, "R8 other reset clears flag, R6 ack clears request");
    step();
    req_ack = 1'b0; other_rst = 1'b0;
    for (int i = 0; i < 4; i++) hold(3);
    if (mon_clk == pol) hold(3);
    hold(T);   // level now pol for exactly T edges: no trip
    expect_out(LAT, 1'b0, 1'b0, "R3 level held exactly timeout");
    expect_out(T + LAT - 1, 1'b0, 1'b0, "R2 no request one edge early");
    expect_out(T + LAT, 1'b1, 1'b1, pol ? "R2 stuck high trips" : "R2 stuck low trips");
    hold(T + 1);
    wait_edges(LAT);
  endtask

  initial begin
    @(negedge ref_clk);
    wait_edges(3);
    expect_out(1, 1'b0, 1'b0, "R1 state during reset");
    step();
    rst = 1'b0;
    expect_out(1, 1'b0, 1'b0, "R1 state after reset");

    // Disabled: long stall must stay quiet
    expect_out(T + LAT + 2, 1'b0, 1'b0, "R5 disabled no request");
    expect_out(3 * T, 1'b0, 1'b0, "R5 disabled long stall");
    wait_edges(3 * T);

    // Enable with the clock stuck low
    det_enable = 1'b1;
    expect_out(T, 1'b0, 1'b0, "R5 no request before timeout after enable");
    expect_out(T + 1, 1'b1, 1'b1, "R5 request after enable with stuck clock");
    wait_edges(T + 1);

    // Acknowledge; flag remains set
    req_ack = 1'b1;
    expect_out(1, 1'b0, 1'b1, "R6 ack clears request, flag kept");
    step();
    req_ack = 1'b0;
    expect_out(2 * T, 1'b0, 1'b1, "R7 no second request on same stall");
    wait_edges(2 * T);

    // Running clock
    expect_out(10, 1'b0, 1'b1, "R4 running clock quiet");
    expect_out(40, 1'b0, 1'b1, "R4 running clock quiet");
    expect_out(80, 1'b0, 1'b1, "R4 running clock quiet");
    for (int i = 0; i < 30; i++) hold(3);

    stall_round(1'b1);
    stall_round(1'b0);

    // Last toggle was LAT edges ago; the stall keeps going.
    // The trip is registered T+LAT edges after that toggle.
    wait_edges(T - 1);
    req_ack = 1'b1;
    expect_out(1, 1'b1, 1'b1, "R9 trip beats ack in same cycle");
    step();
    expect_out(1, 1'b0, 1'b1, "R6 lone ack clears request");
    step();
    req_ack = 1'b0;
    wait_edges(3);

    if (sb.size() != 0) begin
      n_checks++;
      n_fail++;
      $display("FAIL R1 scoreboard: %0d pending items, expected 0", sb.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge ref_clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run not finished, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule